// File: doc/BRIEF.md
# Receiver termination detect controller

This block decides, for each of four link channels, when the far-end receiver termination has been found. It then switches that channel's input common-mode impedance from high-impedance to 50 Ω. While a channel is polling, it issues a one-cycle detect request to an abstracted comparator every poll interval of about 150 µs. The comparator's answer is sampled in that same cycle. The channel counts consecutive positive answers and declares detection once the count required by the mode setting is reached.

A three-bit mode input picks one of five behaviours:

- Code 0 bypasses detection, holds every channel idle and keeps the impedance at 50 Ω.
- Code 1 needs three consecutive hits.
- Code 2 needs two consecutive hits.
- Code 4 is the default and needs a single hit.
- The reserved code 3, and any unused code, behaves like code 4.

Detection restarts in four ways:

- Leaving reset (power-up) restarts all channels.
- A select pulse restarts all channels.
- A power-down pulse that lasts at least the minimum width (200 µs) restarts all channels when power-down is released.
- A per-channel register write restarts only the addressed channel.

While power-down is high, every output impedance is forced to high-impedance and all channel state is frozen. A power-down pulse shorter than the minimum leaves the state as it was.

Top module: `rxd_term_det_ctrl`

## Requirements
- R1: While reset is asserted and after its release, every channel reports status 01 (polling), term_50 is 0 and no detect request is issued until the first poll interval has elapsed.
- R2: A polling channel raises det_req for exactly one cycle, once every POLL_CYC cycles. The first request comes in the POLL_CYC-th cycle after polling starts, and det_hit is sampled in the request cycle.
- R3: With mode 4 (default), mode 3 (reserved) or codes 5 to 7, one positive result completes detection.
- R4: With mode 2, two consecutive positive results are needed.
- R5: With mode 1, three consecutive positive results are needed.
- R6: A negative result clears the consecutive-hit count, and polling continues at the same interval.
- R7: A detected channel reports status 10, drives term_50 high and issues no further requests.
- R8: With mode 0 and power-down low, every channel reports status 00 (idle), term_50 is 1 on all channels and no requests are issued. This takes effect one clock after the mode is applied.
- R9: While pwr_dn is high, term_50 is 0 on every channel in every mode, and channel status does not change.
- R10: A power-down pulse high for at least PD_CYC clock edges restarts polling on all channels at the edge where it is seen low. A shorter pulse leaves every channel's state unchanged.
- R11: A sel_evt pulse restarts polling on all channels at the next edge, clearing their count and interval timer.
- R12: A reg_wr pulse restarts only the channel numbered reg_ch (status field bits [2*ch+1:2*ch]); the others keep their state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| pwr_dn | input | 1 | Power-down; forces high-impedance and freezes state |
| sel_evt | input | 1 | One-cycle pulse restarting all channels |
| mode | input | 3 | Detect mode code 0 to 4 (higher codes act as 4) |
| reg_wr | input | 1 | One-cycle register-write restart strobe |
| reg_ch | input | CW | Channel addressed by reg_wr |
| det_hit | input | NCH | Comparator answer per channel, valid in the request cycle |
| det_req | output | NCH | One-cycle detect request per channel |
| term_50 | output | NCH | 1 = 50 Ω common-mode termination, 0 = high-impedance |
| ch_status | output | 2*NCH | Per-channel status: 00 idle, 01 polling, 10 detected |

## Verification
Every restart source (reset release, sel_evt, a long power-down release, reg_wr) takes effect at the first clock edge that samples it. From that edge, the k-th request falls in the cycle after edge POLL_CYC·k−1 and detection shows at edge POLL_CYC·k. The bench therefore checks polling status and the request count at the negedge just before that edge, and checks detected status and term_50 at the negedge just after it. term_50 reacts to pwr_dn without a register, so it is checked right after pwr_dn is driven. Status effects of power-down and of mode 0 are checked one edge after they are applied.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_POLL = 2'b01,
    ST_DET  = 2'b10
  } ch_st_t;

  // microseconds to clock cycles for a clock given in kHz, never below 2
  function automatic int us_to_cycles(input int us, input int khz);
    int c;
    c = (us * khz) / 1000;
    return (c < 2) ? 2 : c;
  endfunction

  // consecutive positive results needed for a mode code
  function automatic logic [1:0] hits_needed(input logic [2:0] mode_code);
    case (mode_code)
      3'd1:    return 2'd3;
      3'd2:    return 2'd2;
      default: return 2'd1;
    endcase
  endfunction

  function automatic logic is_bypass(input logic [2:0] mode_code);
    return mode_code == 3'd0;
  endfunction

endpackage

// File: rtl/rxd_pd_filter.sv
module rxd_pd_filter #(
  parameter int PD_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_dn,
  output logic restart_long
);
  localparam int PW = $clog2(PD_CYC + 1);

  logic [PW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
    end else if (pwr_dn) begin
      if (hi_cnt < PW'(PD_CYC)) hi_cnt <= hi_cnt + 1'b1;
    end else begin
      hi_cnt <= '0;
    end
  end

  assign restart_long = !pwr_dn && (hi_cnt >= PW'(PD_CYC));
endmodule

// File: rtl/rxd_channel.sv
module rxd_channel
  import rxd_pkg::*;
#(
  parameter int POLL_CYC = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold,
  input  logic       bypass,
  input  logic       restart,
  input  logic [1:0] need,
  input  logic       det_hit,
  output logic       det_req,
  output ch_st_t     st
);
  localparam int TW = $clog2(POLL_CYC);

  logic [TW-1:0] tmr;
  logic [1:0]    run;
  logic          poll_due;
  logic [2:0]    run_next;

  assign poll_due = (st == ST_POLL) && (tmr == TW'(POLL_CYC - 1));
  assign det_req  = poll_due && !hold && !bypass;
  assign run_next = {1'b0, run} + 3'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_POLL;
      tmr <= '0;
      run <= '0;
    end else if (hold) begin
      st  <= st;
    end else if (bypass) begin
      st  <= ST_IDLE;
      tmr <= '0;
      run <= '0;
    end else if (restart) begin
      st  <= ST_POLL;
      tmr <= '0;
      run <= '0;
    end else if (st == ST_POLL) begin
      if (poll_due) begin
        tmr <= '0;
        if (det_hit) begin
          if (run_next >= {1'b0, need}) begin
            st  <= ST_DET;
            run <= '0;
          end else begin
            run <= run_next[1:0];
          end
        end else begin
          run <= '0;
        end
      end else begin
        tmr <= tmr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxd_term_det_ctrl.sv
module rxd_term_det_ctrl
  import rxd_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int CLK_KHZ = 100000,
  parameter int POLL_US = 150,
  parameter int PD_US   = 200,
  localparam int CW     = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_dn,
  input  logic             sel_evt,
  input  logic [2:0]       mode,
  input  logic             reg_wr,
  input  logic [CW-1:0]    reg_ch,
  input  logic [NCH-1:0]   det_hit,
  output logic [NCH-1:0]   det_req,
  output logic [NCH-1:0]   term_50,
  output logic [2*NCH-1:0] ch_status
);
  localparam int POLL_CYC = us_to_cycles(POLL_US, CLK_KHZ);
  localparam int PD_CYC   = us_to_cycles(PD_US, CLK_KHZ);

  // named internal events
  logic           restart_long;
  logic           restart_all;
  logic           mode_bypass;
  logic [1:0]     need;
  logic [NCH-1:0] restart_ch;

  assign mode_bypass = is_bypass(mode);
  assign need        = hits_needed(mode);
  assign restart_all = restart_long || (sel_evt && !pwr_dn);

  rxd_pd_filter #(.PD_CYC(PD_CYC)) pd_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_dn       (pwr_dn),
    .restart_long (restart_long)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    ch_st_t st;

    assign restart_ch[i] = restart_all || (reg_wr && (reg_ch == CW'(i)));

    rxd_channel #(.POLL_CYC(POLL_CYC)) ch_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold    (pwr_dn),
      .bypass  (mode_bypass),
      .restart (restart_ch[i]),
      .need    (need),
      .det_hit (det_hit[i]),
      .det_req (det_req[i]),
      .st      (st)
    );

    assign ch_status[2*i +: 2] = st;
    assign term_50[i] = !pwr_dn && (mode_bypass || (st == ST_DET));
  end
endmodule

// File: rtl/rxd_checker.sv
module rxd_checker #(
  parameter int NCH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_dn,
  input logic [2:0]       mode,
  input logic [NCH-1:0]   det_hit,
  input logic [NCH-1:0]   det_req,
  input logic [NCH-1:0]   term_50,
  input logic [2*NCH-1:0] ch_status
);
  // R9
  pd_forces_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |-> (term_50 == '0));

  // R9
  pd_freezes_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> $stable(ch_status));

  // R8
  bypass_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_dn && mode == 3'd0) |-> (term_50 == '1));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R2
    req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      det_req[i] |=> !det_req[i]);

    // R2
    req_only_polling_chk: assert property (@(posedge clk) disable iff (!rst_n)
      det_req[i] |-> (ch_status[2*i +: 2] == 2'b01));

    // R7
    det_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_status[2*i +: 2] == 2'b10 && $past(ch_status[2*i +: 2]) != 2'b10)
        |-> $past(det_req[i] && det_hit[i]));
  end
endmodule

bind rxd_term_det_ctrl rxd_checker #(.NCH(NCH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_dn    (pwr_dn),
  .mode      (mode),
  .det_hit   (det_hit),
  .det_req   (det_req),
  .term_50   (term_50),
  .ch_status (ch_status)
);

// File: tb/rxd_term_det_ctrl_tb.sv
module rxd_term_det_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 4;
  localparam int KHZ  = 100;
  localparam int POLL = 15;   // 150 us at 100 kHz
  localparam int PDW  = 20;   // 200 us at 100 kHz
  localparam int NV   = 8;

  // {mode, hit pattern (bit0 = first request), requests until detected}
  localparam logic [14:0] VEC [NV] = '{
    {3'd4, 8'b00000001, 4'd1},
    {3'd4, 8'b00000100, 4'd3},
    {3'd2, 8'b00000011, 4'd2},
    {3'd2, 8'b00001101, 4'd4},
    {3'd1, 8'b00000111, 4'd3},
    {3'd1, 8'b00111011, 4'd6},
    {3'd3, 8'b00000010, 4'd2},
    {3'd1, 8'b01110110, 4'd7}
  };

  logic clk = 0;
  logic rst_n = 0;
  logic pwr_dn = 0, sel_evt = 0, reg_wr = 0;
  logic [2:0] mode = 3'd4;
  logic [1:0] reg_ch = '0;
  logic [NCH-1:0] det_hit, det_req, term_50;
  logic [2*NCH-1:0] ch_status;

  logic [7:0] pat = 8'hFF;
  logic cnt_clr = 0;
  int ptr = 0;
  int reqcnt = 0;
  int n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign det_hit = {NCH{(ptr > 7) ? 1'b1 : pat[ptr[2:0]]}};

  always @(posedge clk) begin
    if (cnt_clr) begin
      ptr <= 0;
      reqcnt <= 0;
    end else if (det_req[0]) begin
      ptr <= ptr + 1;
      reqcnt <= reqcnt + 1;
    end
  end

  rxd_term_det_ctrl #(.NCH(NCH), .CLK_KHZ(KHZ)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .sel_evt(sel_evt),
    .mode(mode), .reg_wr(reg_wr), .reg_ch(reg_ch), .det_hit(det_hit),
    .det_req(det_req), .term_50(term_50), .ch_status(ch_status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 status in reset", ch_status, 8'h55);
    chk("R1 term in reset", term_50, 4'h0);
    chk("R1 req in reset", det_req, 4'h0);
    rst_n = 1;
    repeat (POLL - 1) @(posedge clk);
    @(negedge clk);
    chk("R1 still polling", ch_status, 8'h55);
    chk("R2 first request", det_req, 4'hF);
    @(posedge clk); @(negedge clk);
    chk("R3 power-up detect", ch_status, 8'hAA);
    chk("R7 term after detect", term_50, 4'hF);

    // table walk: R3 R4 R5 R6 R11
    for (int v = 0; v < NV; v++) begin
      int k;
      k = int'(VEC[v][3:0]);
      mode = VEC[v][14:12];
      pat = VEC[v][11:4];
      cnt_clr = 1;
      sel_evt = 1;
      @(posedge clk); @(negedge clk);
      cnt_clr = 0;
      sel_evt = 0;
      chk($sformatf("R11 restart v%0d", v), ch_status, 8'h55);
      repeat (POLL * k - 1) @(posedge clk);
      @(negedge clk);
      chk($sformatf("R6 R4 R5 polling before hit v%0d", v), ch_status, 8'h55);
      chk($sformatf("R2 request count v%0d", v), reqcnt, k - 1);
      @(posedge clk); @(negedge clk);
      chk($sformatf("R3 R4 R5 detected v%0d", v), ch_status, 8'hAA);
      chk($sformatf("R7 term v%0d", v), term_50, 4'hF);
      repeat (40) @(posedge clk);
      @(negedge clk);
      chk($sformatf("R7 no more requests v%0d", v), reqcnt, k);
    end

    // R10 short pulse (one edge below minimum)
    mode = 3'd4;
    pat = 8'hFF;
    pwr_dn = 1;
    #1 chk("R9 term forced hiz", term_50, 4'h0);
    repeat (PDW - 1) @(posedge clk);
    @(negedge clk);
    chk("R9 state frozen", ch_status, 8'hAA);
    pwr_dn = 0;
    @(posedge clk); @(negedge clk);
    chk("R10 short pulse keeps state", ch_status, 8'hAA);
    chk("R10 short pulse term", term_50, 4'hF);

    // R10 pulse at exact minimum
    pwr_dn = 1;
    repeat (PDW) @(posedge clk);
    @(negedge clk);
    pwr_dn = 0;
    @(posedge clk); @(negedge clk);
    chk("R10 long pulse restarts", ch_status, 8'h55);
    chk("R10 long pulse term", term_50, 4'h0);
    repeat (POLL) @(posedge clk);
    @(negedge clk);
    chk("R10 redetect after long pulse", ch_status, 8'hAA);

    // R12 single channel restart
    reg_ch = 2'd2;
    reg_wr = 1;
    @(posedge clk); @(negedge clk);
    reg_wr = 0;
    chk("R12 only ch2 restarted", ch_status, 8'h9A);
    chk("R12 term ch2 hiz", term_50, 4'hB);
    repeat (POLL) @(posedge clk);
    @(negedge clk);
    chk("R12 ch2 redetected", ch_status, 8'hAA);

    // R8 bypass
    mode = 3'd0;
    cnt_clr = 1;
    @(posedge clk); @(negedge clk);
    cnt_clr = 0;
    chk("R8 idle status", ch_status, 8'h00);
    chk("R8 term 50", term_50, 4'hF);
    repeat (3 * POLL) @(posedge clk);
    @(negedge clk);
    chk("R8 no requests", reqcnt, 0);
    pwr_dn = 1;
    #1 chk("R9 hiz in bypass", term_50, 4'h0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    pwr_dn = 0;
    #1 chk("R8 term back after pd", term_50, 4'hF);

    summary();
    $finish;
  end
endmodule